// File: doc/BRIEF.md
# Four-Channel PWM Wave Counter

This block drives four pulse-width-modulated outputs from a single shared 15-bit counter. Every channel therefore has the same period, while its duty cycle and polarity come from its own 16-bit compare word. The counter advances on a tick from a power-of-two clock divider. It counts either upward and wraps, which gives edge-aligned pulses, or upward and then back down, which gives center-aligned pulses.

Compare words reach the block through a one-cycle load port that names a channel and carries the word. A loaded word is first held in a staging register. It becomes active only when the counter starts or completes a period, so an output never glitches in the middle of a period. A start strobe latches the top value, the count mode and the divider setting. A stop strobe halts the counter and parks every output at its idle level. A one-cycle marker flags each period boundary, so the feeding logic can supply new words once per period.

Top module: `pwm_wave`

## Requirements
- R1: While reset is held, and after it is released until the first start, `pwm_o` is 0 and `period_end_o` is 0.
- R2: When `mode_i`=0 is latched at start, the counter runs 0,1,…,top and then wraps to 0, so a period lasts top+1 ticks. A channel holds its start level while count < compare and the opposite level otherwise. With top=0 every tick is a period.
- R3: When `mode_i`=1 is latched at start, the counter runs 0 up to top and back down, and the period ends on its return to 0. A period lasts 2·top ticks, or 1 tick when top=0.
- R4: With `prescale_i`=k latched at start, the counter advances once every 2^k clock cycles. The first advance happens 2^k cycles after the start strobe.
- R5: Bit 15 of a compare word selects polarity. A value of 1 means the output starts each period high and falls at the compare match. A value of 0 means it starts low and rises. Bits 14:0 hold the compare value.
- R6: A compare value greater than the latched top gives a steady output at the start level with no edges. A compare value of 0 gives a steady opposite level.
- R7: `top_i`, `mode_i` and `prescale_i` are sampled only in a cycle with `start_i` high. Changing them at other times has no effect on the running period.
- R8: A word loaded with `ld_valid_i`/`ld_chan_i` becomes active only at the next start or period boundary. A word loaded in the same cycle as that boundary waits for the following boundary.
- R9: `period_end_o` is high for exactly the first cycle after each boundary, which is the cycle in which the counter is 0 again. A start does not raise it.
- R10: `stop_i` halts the counter, suppresses `period_end_o` and drives each output to the start level given by its active polarity bit. When `stop_i` and `start_i` are high together, stop wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe: latches settings and restarts the counter |
| stop_i | input | 1 | Stop strobe: halts counter, outputs idle |
| mode_i | input | 1 | 0 = up-only (edge aligned), 1 = up/down (center aligned) |
| prescale_i | input | 3 | Divider exponent k, tick every 2^k cycles |
| top_i | input | 15 | Counter top value |
| ld_valid_i | input | 1 | Compare word load strobe |
| ld_chan_i | input | 2 | Channel index for the load |
| ld_word_i | input | 16 | {polarity, compare[14:0]} |
| pwm_o | output | 4 | PWM outputs, one bit per channel |
| period_end_o | output | 1 | One-cycle period boundary marker |

## Verification
The bench targets top=0 in both count modes. A design that mishandles the turn-around there either stalls or produces a spurious extra boundary. It also covers top=1 in up/down mode, where the turn and the return to 0 fall on the same tick. Compare values of 0 and above top are exercised: a wrong comparison sense there toggles an output that should stay steady. Words are loaded mid-period and on the boundary cycle itself, which exposes a design that applies updates immediately or one cycle early. The bench also changes `top_i` while the counter runs and raises stop and start together, which catches top values taken outside a start and the wrong strobe priority.

// File: rtl/pwm_wave_pkg.sv
package pwm_wave_pkg;
  localparam int CNT_W  = 15;
  localparam int NCH    = 4;
  localparam int PRE_W  = 3;
  localparam int WORD_W = CNT_W + 1;
  localparam int CH_W   = $clog2(NCH);

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    logic fall;
    cnt_t cmp;
  } chan_word_t;

  typedef enum logic {CNT_UP = 1'b0, CNT_UPDOWN = 1'b1} cnt_mode_e;

  typedef struct packed {
    logic dir_up;
    cnt_t cnt;
  } step_t;

  // One counter advance; a returned count of zero marks a period boundary.
  function automatic step_t count_step(cnt_mode_e m, logic dir_up, cnt_t cnt, cnt_t top);
    step_t s;
    if (m == CNT_UP) begin
      s.dir_up = 1'b1;
      s.cnt    = (cnt == top) ? '0 : cnt + cnt_t'(1);
    end else if (dir_up && (cnt != top)) begin
      s.dir_up = 1'b1;
      s.cnt    = cnt + cnt_t'(1);
    end else begin
      s.cnt    = (cnt == '0) ? '0 : cnt - cnt_t'(1);
      s.dir_up = (s.cnt == '0);
    end
    return s;
  endfunction

  // Output level of one channel for a given count.
  function automatic logic chan_level(chan_word_t w, cnt_t cnt, logic run);
    if (!run) return w.fall;
    return (cnt < w.cmp) ? w.fall : ~w.fall;
  endfunction
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [PRE_W-1:0] sel,
  output logic             tick
);
  localparam int PC_W = (1 << PRE_W) - 1;

  logic [PC_W-1:0] pcnt;
  logic [PC_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < PC_W; i++) mask[i] = (i < int'(sel));
  end

  assign tick = en && ((pcnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) pcnt <= '0;
    else if (en)       pcnt <= pcnt + PC_W'(1);
  end

  // R4: a divided tick is never followed by another on the next cycle
  p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (sel != '0) && !clr) |=> !tick);
endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr
  import pwm_wave_pkg::*;
#(
  parameter int PRE_W = pwm_wave_pkg::PRE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             tick,
  input  logic             mode_in,
  input  logic [PRE_W-1:0] sel_in,
  input  cnt_t             top_in,
  output logic             running,
  output logic [PRE_W-1:0] sel_q,
  output cnt_t             top_q,
  output cnt_t             cnt,
  output logic             activate,
  output logic             pend
);
  cnt_mode_e mode_q;
  logic      dir_up;
  step_t     nxt;
  logic      wrap;
  logic      go;

  assign nxt      = count_step(mode_q, dir_up, cnt, top_q);
  assign wrap     = running && tick && (nxt.cnt == '0);
  assign go       = start && !stop;
  assign activate = go || (wrap && !start && !stop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
      dir_up  <= 1'b1;
      top_q   <= '0;
      mode_q  <= CNT_UP;
      sel_q   <= '0;
      pend    <= 1'b0;
    end else begin
      pend <= wrap && !start && !stop;
      if (stop) begin
        running <= 1'b0;
        cnt     <= '0;
        dir_up  <= 1'b1;
      end else if (start) begin
        running <= 1'b1;
        cnt     <= '0;
        dir_up  <= 1'b1;
        top_q   <= top_in;
        mode_q  <= cnt_mode_e'(mode_in);
        sel_q   <= sel_in;
      end else if (running && tick) begin
        cnt    <= nxt.cnt;
        dir_up <= nxt.dir_up;
      end
    end
  end

  // R2: count never exceeds the latched top
  p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt <= top_q));
  // R3: reaching top above 1 in up/down mode turns the count downward
  p_ud_turn_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !start && !stop && tick && (mode_q == CNT_UPDOWN) && (cnt == top_q) && (top_q > cnt_t'(1)))
    |=> !dir_up);
  // R4: without a tick the count holds
  p_hold_no_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !tick && !start && !stop) |=> $stable(cnt));
  // R7: top is taken only at a start
  p_top_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(top_q));
  p_start_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !stop) |=> (top_q == $past(top_in)));
  // R9: the boundary marker coincides with a zero count
  p_pend_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> (cnt == '0));
  // R10: stop halts the counter
  p_stop_halts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!running && (cnt == '0) && !pend));
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_wave_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld_en,
  input  chan_word_t ld_word,
  input  logic       activate,
  input  logic       running,
  input  cnt_t       cnt,
  input  cnt_t       top_q,
  output logic       out
);
  chan_word_t staged;
  chan_word_t active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      staged <= '0;
      active <= '0;
    end else begin
      if (activate) active <= staged;
      if (ld_en)    staged <= ld_word;
    end
  end

  assign out = chan_level(active, cnt, running);

  // R8: the active word changes only at a start or boundary
  p_hold_stage_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !activate |=> $stable(active));
  // R6: compare above top leaves the output at its start level
  p_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && (active.cmp > top_q)) |-> (out == active.fall));
endmodule

// File: rtl/pwm_wave.sv
module pwm_wave
  import pwm_wave_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              mode_i,
  input  logic [PRE_W-1:0]  prescale_i,
  input  logic [CNT_W-1:0]  top_i,
  input  logic              ld_valid_i,
  input  logic [CH_W-1:0]   ld_chan_i,
  input  logic [WORD_W-1:0] ld_word_i,
  output logic [NCH-1:0]    pwm_o,
  output logic              period_end_o
);
  logic             running;
  logic             tick;
  logic             activate;
  logic [PRE_W-1:0] sel_q;
  cnt_t             top_q;
  cnt_t             cnt;

  pwm_tick_gen #(.PRE_W(PRE_W)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (start_i),
    .en   (running),
    .sel  (sel_q),
    .tick (tick)
  );

  pwm_period_ctr #(.PRE_W(PRE_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_i),
    .stop    (stop_i),
    .tick    (tick),
    .mode_in (mode_i),
    .sel_in  (prescale_i),
    .top_in  (top_i),
    .running (running),
    .sel_q   (sel_q),
    .top_q   (top_q),
    .cnt     (cnt),
    .activate(activate),
    .pend    (period_end_o)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm_chan u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_en   (ld_valid_i && (ld_chan_i == CH_W'(g))),
      .ld_word (chan_word_t'(ld_word_i)),
      .activate(activate),
      .running (running),
      .cnt     (cnt),
      .top_q   (top_q),
      .out     (pwm_o[g])
    );
  end

  // R1: outputs quiet in the first cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !$past(rst_n) |-> (pwm_o == '0 && !period_end_o));
  // R10: stopped outputs do not move without a load taking effect
  p_stop_still_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start_i) |=> $stable(pwm_o));
endmodule

// File: tb/sim_pwm_wave.sv
`timescale 1ns/1ps
module sim_pwm_wave;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, stop_i, mode_i;
  logic [2:0]  prescale_i;
  logic [14:0] top_i;
  logic        ld_valid_i;
  logic [1:0]  ld_chan_i;
  logic [15:0] ld_word_i;
  logic [3:0]  pwm_o;
  logic        period_end_o;

  always #4 clk = ~clk;

  pwm_wave u0 (.*);

  int    checks = 0;
  int    errors = 0;
  bit    checking = 0;
  bit    done = 0;
  string tag = "R2";

  // reference model state
  bit          m_run, m_mode, m_pe;
  int          m_top, m_k, m_pc, m_ph;
  logic [15:0] m_stg [4];
  logic [15:0] m_act [4];

  function automatic int per_len(int top, bit md);
    if (!md) return top + 1;
    return (top == 0) ? 1 : 2 * top;
  endfunction

  function automatic int count_at(int ph, int top, bit md);
    if (!md) return ph;
    return (ph <= top) ? ph : 2 * top - ph;
  endfunction

  function automatic logic [3:0] exp_pwm();
    logic [3:0] v;
    int c;
    c = count_at(m_ph, m_top, m_mode);
    for (int i = 0; i < 4; i++) begin
      if (!m_run) v[i] = m_act[i][15];
      else v[i] = (c < int'(m_act[i][14:0])) ? m_act[i][15] : ~m_act[i][15];
    end
    return v;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_mode = 0; m_pe = 0; m_top = 0; m_k = 0; m_pc = 0; m_ph = 0;
      for (int i = 0; i < 4; i++) begin m_stg[i] = '0; m_act[i] = '0; end
    end else begin
      if (stop_i) begin
        m_run = 0; m_ph = 0; m_pe = 0;
      end else if (start_i) begin
        m_run = 1; m_top = int'(top_i); m_mode = mode_i; m_k = int'(prescale_i);
        m_pc = 0; m_ph = 0; m_pe = 0;
        for (int i = 0; i < 4; i++) m_act[i] = m_stg[i];
      end else if (m_run) begin
        bit t;
        t = (((m_pc + 1) % (1 << m_k)) == 0);
        m_pc++;
        m_pe = 0;
        if (t) begin
          m_ph++;
          if (m_ph == per_len(m_top, m_mode)) begin
            m_ph = 0; m_pe = 1;
            for (int i = 0; i < 4; i++) m_act[i] = m_stg[i];
          end
        end
      end else m_pe = 0;
      if (ld_valid_i) m_stg[ld_chan_i] = ld_word_i;
    end
  end

  always @(negedge clk) begin
    if (rst_n && checking && !done) begin
      logic [3:0] e;
      e = exp_pwm();
      chk(pwm_o === e, tag, int'(pwm_o), int'(e));
      chk(period_end_o === m_pe, "R9", int'(period_end_o), int'(m_pe));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  task automatic load(int ch, logic [15:0] w);
    ld_valid_i = 1; ld_chan_i = 2'(ch); ld_word_i = w;
    @(negedge clk);
    ld_valid_i = 0;
  endtask

  task automatic do_start(int top, bit md, int k);
    top_i = 15'(top); mode_i = md; prescale_i = 3'(k); start_i = 1;
    @(negedge clk);
    start_i = 0;
  endtask

  task automatic measure(int exp, string req);
    int n = 0;
    int guard = 0;
    while (!period_end_o && guard < 4000) begin @(negedge clk); guard++; end
    do begin @(negedge clk); n++; end while (!period_end_o && n < 4000);
    chk(n == exp, req, n, exp);
  endtask

  initial begin
    rst_n = 0; start_i = 0; stop_i = 0; mode_i = 0; prescale_i = 0; top_i = 0;
    ld_valid_i = 0; ld_chan_i = 0; ld_word_i = 0;
    repeat (3) @(negedge clk);
    chk(pwm_o === 4'b0, "R1", int'(pwm_o), 0);
    chk(period_end_o === 1'b0, "R1", int'(period_end_o), 0);
    rst_n = 1;
    @(negedge clk);
    chk(pwm_o === 4'b0 && period_end_o === 1'b0, "R1", int'(pwm_o), 0);
    checking = 1;

    // R5/R6 channel setup: falling cmp3, rising cmp5, falling above top, rising cmp0
    tag = "R5";
    load(0, 16'h8003);
    load(1, 16'h0005);
    load(2, 16'h8014);
    load(3, 16'h0000);
    do_start(9, 0, 0);
    tag = "R2";
    measure(10, "R2");
    begin
      int bad = 0;
      for (int i = 0; i < 30; i++) begin
        if (pwm_o[2] !== 1'b1 || pwm_o[3] !== 1'b1) bad++;
        @(negedge clk);
      end
      chk(bad == 0, "R6", bad, 0);
    end

    // R7: top change while running is ignored
    tag = "R7";
    top_i = 15'd4; mode_i = 1; prescale_i = 3'd3;
    measure(10, "R7");

    // R8: mid-period load waits for boundary
    tag = "R8";
    repeat (3) @(negedge clk);
    load(0, 16'h0008);
    measure(10, "R8");
    while (!period_end_o) @(negedge clk);
    @(posedge clk);
    ld_valid_i = 0;
    @(negedge clk);

    // R4 prescaler and R3 up/down periods
    tag = "R4";
    do_start(6, 0, 2);
    measure(28, "R4");
    tag = "R3";
    do_start(6, 1, 3);
    measure(96, "R3");
    do_start(1, 1, 0);
    measure(2, "R3");
    do_start(0, 1, 0);
    measure(1, "R3");
    tag = "R2";
    do_start(0, 0, 1);
    measure(2, "R2");

    // R10: stop parks outputs at their polarity levels
    tag = "R10";
    do_start(7, 1, 0);
    repeat (5) @(negedge clk);
    stop_i = 1; @(negedge clk); stop_i = 0;
    begin
      logic [3:0] idle;
      int pe_seen = 0;
      for (int i = 0; i < 4; i++) idle[i] = m_act[i][15];
      chk(pwm_o === idle, "R10", int'(pwm_o), int'(idle));
      for (int i = 0; i < 15; i++) begin
        if (period_end_o) pe_seen++;
        @(negedge clk);
      end
      chk(pe_seen == 0, "R10", pe_seen, 0);
      start_i = 1; stop_i = 1; top_i = 15'd3; @(negedge clk);
      start_i = 0; stop_i = 0;
      repeat (10) @(negedge clk);
      chk(pwm_o === idle && period_end_o === 1'b0, "R10", int'(pwm_o), int'(idle));
    end

    // random mix
    tag = "R8";
    void'($urandom(32'd20240611));
    for (int seg = 0; seg < 30; seg++) begin
      do_start(int'($urandom_range(0, 24)), 1'($urandom_range(0, 1)), int'($urandom_range(0, 3)));
      for (int c = 0; c < 250; c++) begin
        ld_valid_i = ($urandom_range(0, 3) == 0);
        ld_chan_i  = 2'($urandom_range(0, 3));
        ld_word_i  = {1'($urandom_range(0, 1)), 15'($urandom_range(0, 28))};
        top_i      = 15'($urandom_range(0, 30));
        mode_i     = 1'($urandom_range(0, 1));
        prescale_i = 3'($urandom_range(0, 3));
        stop_i     = ($urandom_range(0, 199) == 0);
        start_i    = ($urandom_range(0, 149) == 0);
        @(negedge clk);
      end
      ld_valid_i = 0; stop_i = 0; start_i = 0;
    end
    @(negedge clk);
    finish_run();
  end
endmodule